// File: doc/BRIEF.md
# Hardware Trap Priority Controller

This block gathers hardware exception events into sticky trap flags and picks one of them by fixed priority. It presents the CPU with a trap number, the priority level of that trap and a request line. The block records eight trap causes, split into two classes. The four urgent causes (non-maskable interrupt, stack overflow, stack underflow, software break) each have their own trap number and a fixed order among themselves. The four fault causes (undefined opcode, parity error on an instruction fetch, protection fault, illegal word operand access) all share one trap number.

Software reads the flag register through a plain write port and a read-back bus, and clears or sets flags with it. A flag that software sets behaves exactly like one that hardware sets. The block keeps a small record of the levels the CPU is servicing. This lets an urgent trap interrupt a fault handler, while a fault can never interrupt an urgent handler. The CPU acknowledges entry into a trap and signals each return from a trap. A flag that is still set after a return raises the request again.

Three reset sources (power-on/hardware, software, watchdog overflow) outrank everything else. Any of them raises a separate reset request and wipes all flags and the in-service record.

Top module: `trap_prio_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `flags_o` is 0, `trap_req_o` is 0, `inserv_lvl_o` is 0 and `rst_req_o` is 0.
- R2: A one-cycle event pulse sets its flag one clock later. The bit positions are: bit 7 NMI, bit 6 stack overflow, bit 5 stack underflow, bit 4 software break, bit 3 protection fault, bit 2 illegal word operand access, bit 1 instruction-fetch parity error, bit 0 undefined opcode.
- R3: A set flag stays set until a register write gives it 0 or a reset source is seen. Idle cycles and trap acknowledge/return do not clear it.
- R4: A register write (`reg_we_i` with `reg_wdata_i`) loads all eight flags one clock later. A flag written to 1 raises the same request, number and level as one set by hardware.
- R5: If a hardware event and a register write of 0 hit the same flag in the same cycle, the flag ends up set.
- R6: Among urgent flags (bits 7..4) the highest bit wins, with trap numbers NMI 0x02, stack overflow 0x04, stack underflow 0x06 and software break 0x08. These are reported at level 2. Any urgent flag wins over every fault flag.
- R7: When only fault flags (bits 3..0) are set, the trap number is 0x0A at level 1. With no flag set, the number is 0x00 at level 0.
- R8: `trap_req_o` is 1 exactly when the pending level is strictly greater than `inserv_lvl_o`. Levels are coded 0 for none, 1 for fault and 2 for urgent.
- R9: `trap_ack_i` while a request is presented marks the presented level as in service. `trap_ret_i` removes the highest level in service, so that returning from an urgent trap nested in a fault handler leaves level 1.
- R10: Any of `rst_hw_i`, `rst_sw_i`, `rst_wdt_i` has three effects one clock later. `rst_req_o` is 1, all flags are 0 and the in-service level is 0, even if a trap event arrives in the same cycle.
- R11: A flag still set when the last in-service level is removed raises `trap_req_o` again with its trap number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_hw_i | input | 1 | Hardware reset source |
| rst_sw_i | input | 1 | Software reset source |
| rst_wdt_i | input | 1 | Watchdog overflow reset source |
| ev_nmi_i | input | 1 | Non-maskable interrupt event pulse |
| ev_stkof_i | input | 1 | Stack overflow event pulse |
| ev_stkuf_i | input | 1 | Stack underflow event pulse |
| ev_sbrk_i | input | 1 | Software break event pulse |
| ev_prot_i | input | 1 | Protection fault event pulse |
| ev_illw_i | input | 1 | Illegal word operand access event pulse |
| ev_parity_i | input | 1 | Instruction-fetch parity error pulse |
| ev_undop_i | input | 1 | Undefined opcode event pulse |
| reg_we_i | input | 1 | Flag register write strobe |
| reg_wdata_i | input | 8 | Flag register write data |
| flags_o | output | 8 | Flag register read-back |
| trap_ack_i | input | 1 | CPU enters the presented trap |
| trap_ret_i | input | 1 | CPU returns from a trap |
| trap_req_o | output | 1 | Trap request |
| trap_vec_o | output | 8 | Trap number of the winning flag |
| trap_lvl_o | output | 2 | Level of the winning flag |
| inserv_lvl_o | output | 2 | Highest level in service |
| rst_req_o | output | 1 | Reset request |

## Verification
A table loads single-bit, multi-bit and mixed flag patterns through the write port. Single bits confirm each trap number on its own. Descending runs of urgent bits show the internal order. Mixtures of urgent and fault bits show that the urgent class dominates and that the fault causes merge into one number. Directed sequences then pulse each event line to confirm its bit position and let a flag sit idle to show it stays set. They also collide an event with a clearing write, and walk a fault handler that an NMI preempts through acknowledge and return, which separates strict-greater request gating from nesting and from re-request on return. A reset source fired together with an event shows that the reset wins.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int unsigned NUM_FLAGS = 8;
    localparam int unsigned NUM_B     = 4;
    localparam int unsigned VEC_W     = 8;
    localparam int unsigned LVL_W     = 2;

    localparam int unsigned FLG_NMI    = 7;
    localparam int unsigned FLG_STKOF  = 6;
    localparam int unsigned FLG_STKUF  = 5;
    localparam int unsigned FLG_SBRK   = 4;
    localparam int unsigned FLG_PROT   = 3;
    localparam int unsigned FLG_ILLW   = 2;
    localparam int unsigned FLG_PARITY = 1;
    localparam int unsigned FLG_UNDOP  = 0;

    localparam logic [VEC_W-1:0] VEC_FAULT = 8'h0A;

    typedef enum logic [LVL_W-1:0] {
        LVL_NONE  = 2'd0,
        LVL_FAULT = 2'd1,
        LVL_URG   = 2'd2
    } lvl_e;

    typedef struct packed {
        lvl_e             lvl;
        logic [VEC_W-1:0] vec;
    } pick_t;

    // Higher index wins within the urgent class; urgent number = 2*(NUM_FLAGS-i).
    function automatic pick_t pick_winner(input logic [NUM_FLAGS-1:0] f);
        pick_t r;
        r.lvl = LVL_NONE;
        r.vec = '0;
        if (|f[NUM_B-1:0]) begin
            r.lvl = LVL_FAULT;
            r.vec = VEC_FAULT;
        end
        for (int i = NUM_B; i < NUM_FLAGS; i++) begin
            if (f[i]) begin
                r.lvl = LVL_URG;
                r.vec = VEC_W'(2 * (NUM_FLAGS - i));
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/trap_flag_bank.sv
module trap_flag_bank
    import trap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_all,
    input  logic [NUM_FLAGS-1:0] hw_set,
    input  logic                 we,
    input  logic [NUM_FLAGS-1:0] wdata,
    output logic [NUM_FLAGS-1:0] flags
);

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                flags[g] <= 1'b0;
            end else if (hw_set[g]) begin
                flags[g] <= 1'b1;
            end else if (we) begin
                flags[g] <= wdata[g];
            end
        end
    end

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags,
    output pick_t                win
);

    always_comb begin
        win = pick_winner(flags);
    end

endmodule

// File: rtl/trap_service_tracker.sv
module trap_service_tracker
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_all,
    input  logic enter,
    input  lvl_e enter_lvl,
    input  logic leave,
    output lvl_e cur_lvl
);

    // bit 1: urgent level active, bit 0: fault level active
    logic [1:0] act_q;
    logic [1:0] act_d;

    always_comb begin
        act_d = act_q;
        if (leave) begin
            if (act_d[1]) begin
                act_d[1] = 1'b0;
            end else begin
                act_d[0] = 1'b0;
            end
        end
        if (enter) begin
            case (enter_lvl)
                LVL_URG:   act_d[1] = 1'b1;
                LVL_FAULT: act_d[0] = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    always_comb begin
        if (act_q[1]) begin
            cur_lvl = LVL_URG;
        end else if (act_q[0]) begin
            cur_lvl = LVL_FAULT;
        end else begin
            cur_lvl = LVL_NONE;
        end
    end

endmodule

// File: rtl/trap_prio_ctrl.sv
module trap_prio_ctrl
    import trap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rst_hw_i,
    input  logic                 rst_sw_i,
    input  logic                 rst_wdt_i,
    input  logic                 ev_nmi_i,
    input  logic                 ev_stkof_i,
    input  logic                 ev_stkuf_i,
    input  logic                 ev_sbrk_i,
    input  logic                 ev_prot_i,
    input  logic                 ev_illw_i,
    input  logic                 ev_parity_i,
    input  logic                 ev_undop_i,
    input  logic                 reg_we_i,
    input  logic [7:0]           reg_wdata_i,
    output logic [7:0]           flags_o,
    input  logic                 trap_ack_i,
    input  logic                 trap_ret_i,
    output logic                 trap_req_o,
    output logic [7:0]           trap_vec_o,
    output logic [1:0]           trap_lvl_o,
    output logic [1:0]           inserv_lvl_o,
    output logic                 rst_req_o
);

    logic                 any_rst_src;
    logic [NUM_FLAGS-1:0] hw_set;
    logic [NUM_FLAGS-1:0] flags;
    pick_t                win;
    lvl_e                 cur_lvl;
    logic                 req;

    assign any_rst_src = rst_hw_i | rst_sw_i | rst_wdt_i;

    always_comb begin
        hw_set             = '0;
        hw_set[FLG_NMI]    = ev_nmi_i;
        hw_set[FLG_STKOF]  = ev_stkof_i;
        hw_set[FLG_STKUF]  = ev_stkuf_i;
        hw_set[FLG_SBRK]   = ev_sbrk_i;
        hw_set[FLG_PROT]   = ev_prot_i;
        hw_set[FLG_ILLW]   = ev_illw_i;
        hw_set[FLG_PARITY] = ev_parity_i;
        hw_set[FLG_UNDOP]  = ev_undop_i;
    end

    trap_flag_bank u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_all (any_rst_src),
        .hw_set  (hw_set),
        .we      (reg_we_i),
        .wdata   (reg_wdata_i),
        .flags   (flags)
    );

    trap_arbiter u_arb (
        .flags (flags),
        .win   (win)
    );

    assign req = (win.lvl > cur_lvl);

    trap_service_tracker u_svc (
        .clk       (clk),
        .rst       (rst),
        .clr_all   (any_rst_src),
        .enter     (trap_ack_i & req),
        .enter_lvl (win.lvl),
        .leave     (trap_ret_i),
        .cur_lvl   (cur_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_o <= 1'b0;
        end else begin
            rst_req_o <= any_rst_src;
        end
    end

    assign flags_o      = flags;
    assign trap_req_o   = req;
    assign trap_vec_o   = win.vec;
    assign trap_lvl_o   = win.lvl;
    assign inserv_lvl_o = cur_lvl;

endmodule

// File: rtl/trap_prio_ctrl_chk.sv
module trap_prio_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       rst_hw_i,
    input logic       rst_sw_i,
    input logic       rst_wdt_i,
    input logic       ev_nmi_i,
    input logic       ev_prot_i,
    input logic       ev_illw_i,
    input logic       reg_we_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] flags_o,
    input logic       trap_req_o,
    input logic [7:0] trap_vec_o,
    input logic [1:0] trap_lvl_o,
    input logic [1:0] inserv_lvl_o,
    input logic       rst_req_o
);

    logic any_src;
    assign any_src = rst_hw_i | rst_sw_i | rst_wdt_i;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (flags_o == 8'h00 && !trap_req_o && inserv_lvl_o == 2'd0));

    a_r2_prot_event_sets: assert property (@(posedge clk) disable iff (rst)
        (ev_prot_i && !any_src) |=> flags_o[3]);

    a_r3_nmi_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags_o[7] && !reg_we_i && !any_src) |=> flags_o[7]);

    a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (ev_illw_i && reg_we_i && !reg_wdata_i[2] && !any_src) |=> flags_o[2]);

    a_r6_nmi_wins: assert property (@(posedge clk) disable iff (rst)
        flags_o[7] |-> (trap_vec_o == 8'h02 && trap_lvl_o == 2'd2));

    a_r7_fault_shared_number: assert property (@(posedge clk) disable iff (rst)
        (flags_o[7:4] == 4'h0 && flags_o[3:0] != 4'h0) |-> (trap_vec_o == 8'h0A && trap_lvl_o == 2'd1));

    a_r8_no_request_in_urgent: assert property (@(posedge clk) disable iff (rst)
        (inserv_lvl_o == 2'd2) |-> !trap_req_o);

    a_r10_reset_source_wipes: assert property (@(posedge clk) disable iff (rst)
        any_src |=> (flags_o == 8'h00 && inserv_lvl_o == 2'd0 && rst_req_o));

    a_r10_event_ignored_in_reset: assert property (@(posedge clk) disable iff (rst)
        (ev_nmi_i && any_src) |=> !trap_req_o);

endmodule

bind trap_prio_ctrl trap_prio_ctrl_chk u_chk (.*);

// File: tb/trap_prio_ctrl_tb.sv
module trap_prio_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    // {flags written, expected number, expected level}
    localparam logic [17:0] VEC_TAB [NVEC] = '{
        {8'h80, 8'h02, 2'd2}, {8'h40, 8'h04, 2'd2}, {8'h20, 8'h06, 2'd2}, {8'h10, 8'h08, 2'd2},
        {8'h08, 8'h0A, 2'd1}, {8'h04, 8'h0A, 2'd1}, {8'h02, 8'h0A, 2'd1}, {8'h01, 8'h0A, 2'd1},
        {8'hF0, 8'h02, 2'd2}, {8'h70, 8'h04, 2'd2}, {8'h30, 8'h06, 2'd2}, {8'h1F, 8'h08, 2'd2},
        {8'h0F, 8'h0A, 2'd1}, {8'h00, 8'h00, 2'd0}, {8'h91, 8'h02, 2'd2}, {8'h6C, 8'h04, 2'd2}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       rst_hw, rst_sw, rst_wdt;
    logic [7:0] ev;
    logic       we;
    logic [7:0] wdata;
    logic [7:0] flags;
    logic       ack, ret;
    logic       req;
    logic [7:0] vec;
    logic [1:0] lvl, inserv;
    logic       rst_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_prio_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .rst_hw_i     (rst_hw),
        .rst_sw_i     (rst_sw),
        .rst_wdt_i    (rst_wdt),
        .ev_nmi_i     (ev[7]),
        .ev_stkof_i   (ev[6]),
        .ev_stkuf_i   (ev[5]),
        .ev_sbrk_i    (ev[4]),
        .ev_prot_i    (ev[3]),
        .ev_illw_i    (ev[2]),
        .ev_parity_i  (ev[1]),
        .ev_undop_i   (ev[0]),
        .reg_we_i     (we),
        .reg_wdata_i  (wdata),
        .flags_o      (flags),
        .trap_ack_i   (ack),
        .trap_ret_i   (ret),
        .trap_req_o   (req),
        .trap_vec_o   (vec),
        .trap_lvl_o   (lvl),
        .inserv_lvl_o (inserv),
        .rst_req_o    (rst_req)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        rst_hw = 0; rst_sw = 0; rst_wdt = 0; ev = '0;
        we = 0; wdata = '0; ack = 0; ret = 0;
    endtask

    task automatic write_flags(input logic [7:0] v);
        we = 1; wdata = v;
        tick();
        we = 0; wdata = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 flags", 32'(flags), 32'h0);
        check("R1 req", 32'(req), 32'h0);
        check("R1 inserv", 32'(inserv), 32'h0);
        check("R1 rst_req", 32'(rst_req), 32'h0);

        // R4 R6 R7 R8 table walk with nothing in service
        for (int i = 0; i < NVEC; i++) begin
            write_flags(VEC_TAB[i][17:10]);
            check("R4 flags", 32'(flags), 32'(VEC_TAB[i][17:10]));
            check("R6_R7 number", 32'(vec), 32'(VEC_TAB[i][9:2]));
            check("R6_R7 level", 32'(lvl), 32'(VEC_TAB[i][1:0]));
            check("R8 request", 32'(req), 32'(VEC_TAB[i][1:0] != 2'd0));
        end
        write_flags(8'h00);

        // R2 each event sets its own bit; R3 it stays over idle cycles
        for (int b = 0; b < 8; b++) begin
            ev = 8'(1 << b);
            tick();
            ev = '0;
            check("R2 event bit", 32'(flags), 32'(1 << b));
            repeat (3) tick();
            check("R3 sticky", 32'(flags), 32'(1 << b));
            write_flags(8'h00);
            check("R3 write clears", 32'(flags), 32'h0);
        end

        // R5 set beats clear
        write_flags(8'h08);
        ev[3] = 1; we = 1; wdata = 8'h00;
        tick();
        idle();
        check("R5 set wins", 32'(flags), 32'h08);
        write_flags(8'h00);

        // R8 R9 R11 nesting
        ev[0] = 1; tick(); idle();
        check("R8 fault req", 32'(req), 32'h1);
        check("R7 fault number", 32'(vec), 32'h0A);
        ack = 1; tick(); idle();
        check("R9 inserv fault", 32'(inserv), 32'h1);
        check("R8 no equal-level req", 32'(req), 32'h0);
        ev[7] = 1; tick(); idle();
        check("R8 urgent preempts", 32'(req), 32'h1);
        check("R6 nmi number", 32'(vec), 32'h02);
        ack = 1; tick(); idle();
        check("R9 inserv urgent", 32'(inserv), 32'h2);
        check("R8 blocked in urgent", 32'(req), 32'h0);
        write_flags(8'h01);
        check("R8 fault blocked by urgent", 32'(req), 32'h0);
        ret = 1; tick(); idle();
        check("R9 return to fault", 32'(inserv), 32'h1);
        check("R3 flag kept over return", 32'(flags), 32'h01);
        check("R8 still no req", 32'(req), 32'h0);
        ret = 1; tick(); idle();
        check("R9 return to none", 32'(inserv), 32'h0);
        check("R11 re-request", 32'(req), 32'h1);
        check("R11 number", 32'(vec), 32'h0A);

        // R10 reset sources
        ack = 1; tick(); idle();
        rst_wdt = 1; ev[7] = 1; tick(); idle();
        check("R10 rst_req wdt", 32'(rst_req), 32'h1);
        check("R10 flags wiped", 32'(flags), 32'h0);
        check("R10 inserv wiped", 32'(inserv), 32'h0);
        check("R10 no req", 32'(req), 32'h0);
        tick();
        check("R10 rst_req drops", 32'(rst_req), 32'h0);
        write_flags(8'h20);
        rst_hw = 1; tick(); idle();
        check("R10 rst_req hw", 32'(rst_req), 32'h1);
        check("R10 hw wipes", 32'(flags), 32'h0);
        rst_sw = 1; tick(); idle();
        check("R10 rst_req sw", 32'(rst_req), 32'h1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule